// File: doc/BRIEF.md
# Character Height Line Repeater

This block stretches an 18-line character glyph to a programmed height of up to 63 scanlines on a display overlay. It repeats selected glyph lines rather than doubling every line. A display controller pulses `row_start` when a character row begins and `line_stb` once for every further scanline. For each scanline the block presents the 0-based glyph line index that the font memory should read. It raises a one-cycle `row_done` pulse once the row has used up its programmed number of scanlines.

The 6-bit height value is split into a base repeat count and an excess `k` in the range 1 to 14. Base 1 applies to heights 19..32, base 2 to 33..46, base 3 to 47..60 and base 4 to 61..63. Every glyph line is shown the base number of times. A sparse set of lines gets one extra copy. Those lines sit at 1-based positions 2+N·M (N ≥ 1, position ≤ 16), where the step M is 14/k rounded with halves going up.

The row always lasts exactly the programmed height. If the repeat schedule runs out early, the final glyph line is held. If the schedule is longer, it is cut short.

Top module: `chh_row_repeater`

## Requirements
- R1: After reset, `line_active` is 0, `row_done` is 0 and `glyph_line` is 0.
- R2: A `row_start` pulse samples `ch_val`. On the next cycle `line_active` is 1, `glyph_line` is 0 and `row_done` is 0. Later changes of `ch_val` inside the row have no effect.
- R3: For a height H in 19..32, with M = round(14/(H-18)) and halves rounded up, each 1-based glyph line 2+N·M (N ≥ 1, position ≤ 16) appears on two consecutive scanlines. Every other line appears on one. Example: H=19 shows index 15 twice; H=20 shows indices 8 and 15 twice.
- R4: For H in 33..46, 47..60 and 61..63, every line appears 2, 3 or 4 times respectively. Lines 2+N·M get one more copy, with M = round(14/k) and k = H-32, H-46 or H-60.
- R5: No glyph line above 1-based position 16 (index 15) ever receives an extra copy.
- R6: A row spans exactly H scanlines: the `row_start` scanline plus H-1 strobes. The strobe that ends scanline H makes `row_done` high for exactly one cycle and drops `line_active` in that same cycle.
- R7: When the repeat schedule has fewer entries than H, index 17 is held for the remaining scanlines. When it has more, the row ends after H scanlines and the remaining entries are dropped.
- R8: A height of 18 or less gives an 18-scanline row that shows each glyph line once.
- R9: A `line_stb` while no row is active changes neither `glyph_line` nor `line_active`, and does not produce `row_done`.
- R10: A `row_start` during an active row restarts the row with the newly sampled height. A `line_stb` in the same cycle as `row_start` is ignored.
- R11: `glyph_line` never exceeds 17. Within a row it advances by zero or one per strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_val | input | 6 | Programmed character height in scanlines |
| row_start | input | 1 | Pulse marking the first scanline of a character row |
| line_stb | input | 1 | Pulse marking each following scanline |
| glyph_line | output | 5 | 0-based glyph line to fetch for the current scanline |
| line_active | output | 1 | High while a character row is in progress |
| row_done | output | 1 | One-cycle pulse when the row's last scanline ends |

## Verification
On every cycle, assertions check the structural rules:
- the glyph index stays at or below 17 and moves by at most one per strobe;
- the repeat count of a line stays within one of the zone base;
- extra copies never land above position 16;
- the row starts cleanly;
- idle strobes leave the state alone;
- `row_done` is a single-cycle pulse that coincides with the row closing.

Only the bench scenarios can show that the exact scanline-by-scanline index sequence matches the 2+N·M rule for each zone. Those scenarios also cover the padding and truncation cases, the row length in strobes, and the behaviour of a restart.

// File: rtl/chh_pkg.sv
// Shared helpers for the character height line repeater.
// Assumes: callers pass positive denominators.
package chh_pkg;

    // Rounded integer ratio, halves rounded up: round(num/den).
    function automatic int round_ratio(input int num, input int den);
        return (2 * num + den) / (2 * den);
    endfunction

endpackage

// File: rtl/chh_height_decode.sv
// Height decoder: splits a programmed character height into a base repeat
// count, a mark step (rounded ZONE / excess) and the effective row height.
// Assumes: heights at or below GLYPH_LINES mean "no stretching".
module chh_height_decode #(
    parameter int CH_W        = 6,
    parameter int GLYPH_LINES = 18,
    parameter int ZONE        = 14,
    parameter int REP_W       = 3,
    parameter int STEP_W      = 4
) (
    input  logic [CH_W-1:0]   ch_val,
    output logic [REP_W-1:0]  base_reps,
    output logic [STEP_W-1:0] step,
    output logic [CH_W-1:0]   height
);
    // Step table round(ZONE/k) for k = 1..ZONE, computed at elaboration.
    logic [STEP_W-1:0] step_tab [1:ZONE];

    for (genvar g = 1; g <= ZONE; g++) begin : g_tab
        assign step_tab[g] = STEP_W'(chh_pkg::round_ratio(ZONE, g));
    end

    // Zone split: base count from the excess band, k within the band.
    always_comb begin
        int over_i;
        int k_i;
        over_i = 0;
        k_i    = 0;
        if (int'(ch_val) > GLYPH_LINES) begin
            over_i    = int'(ch_val) - GLYPH_LINES - 1;
            k_i       = (over_i % ZONE) + 1;
            base_reps = REP_W'(1 + over_i / ZONE);
            height    = ch_val;
        end else begin
            base_reps = REP_W'(1);
            height    = CH_W'(GLYPH_LINES);
        end
        step = '0;
        for (int i = 1; i <= ZONE; i++) begin
            if (k_i == i) step = step_tab[i];
        end
    end

endmodule

// File: rtl/chh_mark_track.sv
// Mark tracker: holds the next 1-based glyph line that earns an extra copy
// (FIRST_MARK + N*step) and flags a hit when the line counter reaches it.
// Assumes: a step of zero disables all marks for the row.
module chh_mark_track #(
    parameter int MARK_W     = 6,
    parameter int STEP_W     = 4,
    parameter int FIRST_MARK = 2,
    parameter int MARK_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [STEP_W-1:0] start_step,
    input  logic              advance,
    input  logic [MARK_W-1:0] cand_line,
    output logic              hit
);
    logic [MARK_W-1:0] next_mark;
    logic [STEP_W-1:0] step_r;
    logic              en_r;

    // A candidate line earns an extra copy if it is the pending mark in range.
    assign hit = en_r && (cand_line == next_mark) && (cand_line <= MARK_W'(MARK_LIMIT));

    // Load the first mark at row start, move to the following one on each hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_mark <= '0;
            step_r    <= '0;
            en_r      <= 1'b0;
        end else if (start) begin
            step_r    <= start_step;
            en_r      <= (start_step != '0);
            next_mark <= MARK_W'(FIRST_MARK) + MARK_W'(start_step);
        end else if (advance && hit) begin
            next_mark <= next_mark + MARK_W'(step_r);
        end
    end

    // R3
    mark_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && hit && !start) |=> (next_mark > $past(next_mark)));

endmodule

// File: rtl/chh_line_count.sv
// Line counter: tracks the current glyph line and how many copies of it have
// been shown, then steps to the next line when its copy count is used up.
// Assumes: step_adv is never asserted together with start.
module chh_line_count #(
    parameter int GLYPH_LINES = 18,
    parameter int GLY_W       = 5,
    parameter int REP_W       = 3,
    parameter int MARK_W      = 6,
    parameter int MARK_LIMIT  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REP_W-1:0]  start_base,
    input  logic              step_adv,
    input  logic              hit,
    output logic [GLY_W-1:0]  glyph,
    output logic [MARK_W-1:0] cand_line,
    output logic              line_adv
);
    localparam logic [GLY_W-1:0] LAST = GLY_W'(GLYPH_LINES - 1);

    logic [GLY_W-1:0] glyph_r;
    logic [REP_W-1:0] rep_r;
    logic [REP_W-1:0] need_r;
    logic [REP_W-1:0] base_r;
    logic             copies_done;

    // Copies of the current line are used up after this scanline.
    assign copies_done = (rep_r + REP_W'(1)) >= need_r;
    assign line_adv    = step_adv && copies_done && (glyph_r < LAST);
    // 1-based position of the line that would follow the current one.
    assign cand_line   = MARK_W'(glyph_r) + MARK_W'(2);
    assign glyph       = glyph_r;

    // Copy counting and line stepping; the last line is held once reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glyph_r <= '0;
            rep_r   <= '0;
            need_r  <= REP_W'(1);
            base_r  <= REP_W'(1);
        end else if (start) begin
            glyph_r <= '0;
            rep_r   <= '0;
            need_r  <= start_base;
            base_r  <= start_base;
        end else if (step_adv) begin
            if (!copies_done) begin
                rep_r <= rep_r + REP_W'(1);
            end else if (glyph_r < LAST) begin
                glyph_r <= glyph_r + GLY_W'(1);
                rep_r   <= '0;
                need_r  <= base_r + REP_W'(hit);
            end
        end
    end

    // R11
    glyph_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        glyph_r <= LAST);

    // R11
    glyph_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_adv && !start) |=> (glyph_r == $past(glyph_r) || glyph_r == $past(glyph_r) + GLY_W'(1)));

    // R4
    need_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (need_r >= base_r) && (need_r <= base_r + REP_W'(1)) && (rep_r < need_r));

    // R5
    mark_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (need_r != base_r) |-> (glyph_r <= GLY_W'(MARK_LIMIT - 1)));

endmodule

// File: rtl/chh_row_repeater.sv
// Character height line repeater (top). For each scanline of a character row
// it presents the glyph line to fetch, stretching an 18-line glyph to the
// programmed height by repeating chosen lines, and pulses row_done at the end.
// Assumes: row_start and line_stb are single-cycle pulses; row_start wins.
module chh_row_repeater #(
    parameter int CH_W        = 6,
    parameter int GLYPH_LINES = 18,
    parameter int ZONE        = 14,
    parameter int FIRST_MARK  = 2,
    parameter int MARK_LIMIT  = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [CH_W-1:0]                ch_val,
    input  logic                           row_start,
    input  logic                           line_stb,
    output logic [$clog2(GLYPH_LINES)-1:0] glyph_line,
    output logic                           line_active,
    output logic                           row_done
);
    localparam int GLY_W   = $clog2(GLYPH_LINES);
    localparam int MAX_REP = ((2 ** CH_W) - 1 - GLYPH_LINES - 1) / ZONE + 2;
    localparam int REP_W   = $clog2(MAX_REP + 1);
    localparam int STEP_W  = $clog2(ZONE + 1);
    localparam int MARK_W  = CH_W;

    logic [REP_W-1:0]  dec_base;
    logic [STEP_W-1:0] dec_step;
    logic [CH_W-1:0]   dec_height;
    logic [CH_W-1:0]   height_r;
    logic [CH_W-1:0]   scan_r;
    logic              active_r;
    logic              done_r;
    logic              stb;
    logic              last_scan;
    logic              step_adv;
    logic              hit;
    logic              line_adv;
    logic [MARK_W-1:0] cand_line;
    logic [GLY_W-1:0]  glyph;

    chh_height_decode #(
        .CH_W(CH_W), .GLYPH_LINES(GLYPH_LINES), .ZONE(ZONE),
        .REP_W(REP_W), .STEP_W(STEP_W)
    ) u_decode (
        .ch_val(ch_val), .base_reps(dec_base), .step(dec_step), .height(dec_height)
    );

    chh_line_count #(
        .GLYPH_LINES(GLYPH_LINES), .GLY_W(GLY_W), .REP_W(REP_W),
        .MARK_W(MARK_W), .MARK_LIMIT(MARK_LIMIT)
    ) u_lines (
        .clk(clk), .rst_n(rst_n), .start(row_start), .start_base(dec_base),
        .step_adv(step_adv), .hit(hit), .glyph(glyph),
        .cand_line(cand_line), .line_adv(line_adv)
    );

    chh_mark_track #(
        .MARK_W(MARK_W), .STEP_W(STEP_W),
        .FIRST_MARK(FIRST_MARK), .MARK_LIMIT(MARK_LIMIT)
    ) u_marks (
        .clk(clk), .rst_n(rst_n), .start(row_start), .start_step(dec_step),
        .advance(line_adv), .cand_line(cand_line), .hit(hit)
    );

    // Strobe qualification: only inside a row and never alongside a restart.
    assign stb       = line_stb && active_r && !row_start;
    assign last_scan = (scan_r == height_r - CH_W'(1));
    assign step_adv  = stb && !last_scan;

    // Scanline counting, row activity and the end-of-row pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_r <= 1'b0;
            scan_r   <= '0;
            height_r <= CH_W'(GLYPH_LINES);
            done_r   <= 1'b0;
        end else if (row_start) begin
            active_r <= 1'b1;
            scan_r   <= '0;
            height_r <= dec_height;
            done_r   <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (stb) begin
                if (last_scan) begin
                    active_r <= 1'b0;
                    done_r   <= 1'b1;
                end else begin
                    scan_r <= scan_r + CH_W'(1);
                end
            end
        end
    end

    assign glyph_line  = glyph;
    assign line_active = active_r;
    assign row_done    = done_r;

    // R2
    row_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_start |=> (line_active && glyph_line == '0 && !row_done));

    // R6
    done_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |-> (!line_active && $past(line_active)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |=> !row_done);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_active && !row_start) |=> (!line_active && !row_done && $stable(glyph_line)));

endmodule

// File: tb/tb_chh_row_repeater.sv
`timescale 1ns/1ps
module tb_chh_row_repeater;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] ch_val = '0;
    logic       row_start = 1'b0;
    logic       line_stb = 1'b0;
    logic [4:0] glyph_line;
    logic       line_active;
    logic       row_done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int exp_seq [64];
    int exp_len;

    always #2 clk = ~clk;

    chh_row_repeater dut (
        .clk(clk), .rst_n(rst_n), .ch_val(ch_val), .row_start(row_start),
        .line_stb(line_stb), .glyph_line(glyph_line),
        .line_active(line_active), .row_done(row_done)
    );

    task automatic chk(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Expected scanline sequence from the requirements (modulo form of 2+N*M).
    task automatic build_exp(input int ch);
        int h, base, k, m, idx, reps;
        idx = 0;
        if (ch <= 18) begin
            h = 18; base = 1; k = 0; m = 0;
        end else begin
            h = ch; base = (ch - 19) / 14 + 1; k = (ch - 19) % 14 + 1;
            m = (28 + k) / (2 * k);
        end
        for (int ln = 1; ln <= 18; ln++) begin
            reps = base;
            if (k != 0 && ln >= 2 + m && ln <= 16 && ((ln - 2) % m) == 0) reps++;
            for (int r = 0; r < reps; r++) begin
                if (idx < h) begin
                    exp_seq[idx] = ln - 1;
                    idx++;
                end
            end
        end
        while (idx < h) begin
            exp_seq[idx] = 17;
            idx++;
        end
        exp_len = h;
    endtask

    task automatic start_row(input int ch);
        @(negedge clk);
        ch_val = 6'(ch);
        row_start = 1'b1;
        @(negedge clk);
        row_start = 1'b0;
    endtask

    task automatic strobe();
        line_stb = 1'b1;
        @(negedge clk);
        line_stb = 1'b0;
    endtask

    // Walk scanlines from index 'from', checking each, then the row end.
    task automatic run_body(input string req, input int from);
        for (int s = from; s < exp_len; s++) begin
            chk(req, glyph_line, exp_seq[s]);
            strobe();
            if (s < exp_len - 1) chk({req, "/R6 early done"}, row_done, 0);
        end
        chk("R6 done pulse", row_done, 1);
        chk("R6 active fall", line_active, 0);
        @(negedge clk);
        chk("R6 done width", row_done, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 active", line_active, 0);
        chk("R1 done", row_done, 0);
        chk("R1 glyph", glyph_line, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_row(input string req, input int ch);
        build_exp(ch);
        start_row(ch);
        chk("R2 active", line_active, 1);
        chk("R2 glyph0", glyph_line, 0);
        ch_val = 6'(~ch);   // R2: change after sampling must be ignored
        run_body(req, 0);
    endtask

    task automatic t_idle();
        int held;
        held = glyph_line;
        for (int i = 0; i < 3; i++) strobe();
        chk("R9 idle active", line_active, 0);
        chk("R9 idle done", row_done, 0);
        chk("R9 idle glyph", glyph_line, held);
    endtask

    task automatic t_restart();
        start_row(30);
        for (int i = 0; i < 5; i++) strobe();
        // R10: restart with a simultaneous strobe, which must be ignored
        build_exp(20);
        ch_val = 6'd20;
        row_start = 1'b1;
        line_stb = 1'b1;
        @(negedge clk);
        row_start = 1'b0;
        line_stb = 1'b0;
        chk("R10 restart active", line_active, 1);
        chk("R10 restart glyph", glyph_line, 0);
        run_body("R10", 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_row("R3", 19);
        t_row("R3", 20);
        t_row("R7 pad", 22);
        t_row("R7 trunc", 24);
        t_row("R3", 32);
        t_row("R4", 33);
        t_row("R4", 40);
        t_row("R4", 50);
        t_row("R4", 60);
        t_row("R5", 61);
        t_row("R4", 63);
        t_row("R8", 10);
        t_row("R8", 18);
        t_idle();
        t_restart();
        t_row("R11", 45);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule